// File: doc/BRIEF.md
# Indirect-Indexed Codec Control Register File

This block is the control register file of an audio codec. A processor reaches it through a small word-addressed bus, 32 bits wide, with separate read and write strobes. It holds sixteen 32-bit direct registers. It also holds thirty-two 8-bit indirect registers, which software reaches through a pointer-and-window pair. Direct register 0 acts as the pointer: its low five bits pick the indirect register. Direct register 1 is the window onto the register that the pointer selects.

Each register follows its own access rule. One indirect slot can be written but always reads as zero. Two indirect slots hold fixed values and ignore writes. One indirect slot keeps a single writable bit and always shows a fixed codec version in its other bits. Direct register 2 always reads as zero. Direct register 4 stores only seven bits. A write to register 4 with its lowest bit set returns the whole file to its power-up contents in the same cycle, and the written value is still stored in register 4. The interrupt output is present but never asserts.

Top module: `codec_regfile`

## Requirements
- R1: After reset every direct register reads 0x00000000, every indirect register reads 0x00, indirect 12 reads 0x8A and indirect 25 reads 0xA0.
- R2: Direct registers 0, 3 and 5 to 15 store all 32 written bits and return them on read. The word number is bus_addr[5:2].
- R3: A read or write of direct word 1 reaches the indirect register whose index is bits [4:0] of direct register 0. Bits [31:5] of register 0 do not affect the index. Read data from word 1 is the 8-bit value zero-extended to 32 bits. A write to word 1 uses bus_wdata[7:0].
- R4: A read through word 1 while the index is 3 returns zero, whatever was written there.
- R5: Writes through word 1 to indices 11 and 25 leave those registers unchanged. Index 11 reads 0x00 and index 25 reads 0xA0.
- R6: A write through word 1 to index 12 stores (wdata & 0x40) | 0x8A.
- R7: Direct word 2 always reads zero. Writes to it change nothing.
- R8: A write to direct word 4 stores wdata & 0x7F. When bit 0 is clear, no other register changes.
- R9: A write to direct word 4 with bit 0 set restores every direct and indirect register to its R1 value, including the index in register 0. In the same cycle, register 4 takes wdata & 0x7F.
- R10: Read data is registered. It appears on bus_rdata on the cycle after the cycle in which bus_rd is high, and it holds until the next read.
- R11: irq stays low at all times.
- R12: When bus_rd and bus_wr are both high in the same cycle, the read returns the value held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 6 | Byte address; bits [5:2] select the word |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq | output | 1 | Interrupt request, held low |

## Verification
The hardest state to reach is the soft reset. It must clear the pointer and every indirect slot, restore both version bytes, and still leave the triggering value in register 4. All of this happens on one edge. To reach it, the stimulus first fills every indirect slot and the plain direct registers with distinct patterns. It then issues a register-4 write with bit 0 clear and confirms that nothing else moved. Next it issues a register-4 write with bit 0 set and upper garbage bits, and reads back register 4, the pointer, a plain register and several indirect slots. A separate step aims the pointer with junk in its upper bits, to show that only the low five bits select the slot.

// File: rtl/codec_regs_pkg.sv
package codec_regs_pkg;

  typedef logic [31:0] word_t;
  typedef logic [7:0]  ibyte_t;

  typedef enum logic [1:0] {DK_PLAIN, DK_PORT, DK_ZERO, DK_CTRL} dir_kind_e;

  localparam int WORD_INDEX   = 0;
  localparam int WORD_DATA    = 1;
  localparam int WORD_ZERO    = 2;
  localparam int WORD_CTRL    = 4;
  localparam int SOFT_RST_BIT = 0;

  localparam int IDX_WONLY    = 3;
  localparam int IDX_LOCKED   = 11;
  localparam int IDX_CODECVER = 12;
  localparam int IDX_CHIPVER  = 25;

  localparam ibyte_t CODEC_VER  = 8'h8A;
  localparam ibyte_t CHIP_VER   = 8'hA0;
  localparam ibyte_t KEEP_MASK  = 8'h40;
  localparam word_t  CTRL_MASK  = 32'h0000_007F;

  function automatic dir_kind_e dir_kind(int w);
    case (w)
      WORD_DATA: return DK_PORT;
      WORD_ZERO: return DK_ZERO;
      WORD_CTRL: return DK_CTRL;
      default:   return DK_PLAIN;
    endcase
  endfunction

  function automatic ibyte_t ind_reset_val(int idx);
    if (idx == IDX_CODECVER) return CODEC_VER;
    if (idx == IDX_CHIPVER)  return CHIP_VER;
    return 8'h00;
  endfunction

  function automatic logic ind_writable(int idx);
    return !(idx == IDX_LOCKED || idx == IDX_CHIPVER);
  endfunction

  function automatic ibyte_t ind_store_val(int idx, ibyte_t wd);
    if (idx == IDX_CODECVER) return (wd & KEEP_MASK) | CODEC_VER;
    return wd;
  endfunction

  function automatic ibyte_t ind_read_val(int idx, ibyte_t q);
    if (idx == IDX_WONLY) return 8'h00;
    return q;
  endfunction

  function automatic word_t ctrl_store_val(word_t wd);
    return wd & CTRL_MASK;
  endfunction

endpackage

// File: rtl/codec_dir_bank.sv
module codec_dir_bank
  import codec_regs_pkg::*;
#(
  parameter int DIR_COUNT = 16,
  localparam int WORD_AW = $clog2(DIR_COUNT)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [WORD_AW-1:0]         wr_word,
  input  word_t                      wdata,
  input  logic                       soft_clr,
  output logic [DIR_COUNT-1:0][31:0] regs_o
);

  for (genvar w = 0; w < DIR_COUNT; w++) begin : g_dir
    localparam dir_kind_e KIND = dir_kind(w);
    logic hit;
    assign hit = wr_en && (wr_word == WORD_AW'(w));

    if (KIND == DK_PLAIN) begin : g_plain
      word_t q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        q <= '0;
        else if (hit)      q <= wdata;
        else if (soft_clr) q <= '0;
      end
      assign regs_o[w] = q;
    end else if (KIND == DK_CTRL) begin : g_ctrl
      word_t q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        q <= '0;
        else if (hit)      q <= ctrl_store_val(wdata);
        else if (soft_clr) q <= '0;
      end
      assign regs_o[w] = q;
    end else begin : g_none
      logic unused_hit;
      assign unused_hit = hit;
      assign regs_o[w] = '0;
    end
  end

endmodule

// File: rtl/codec_ind_bank.sv
module codec_ind_bank
  import codec_regs_pkg::*;
#(
  parameter int IND_COUNT = 32,
  localparam int IDX_W = $clog2(IND_COUNT)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [IDX_W-1:0]          wr_idx,
  input  ibyte_t                    wdata,
  input  logic                      soft_clr,
  output logic [IND_COUNT-1:0][7:0] regs_o
);

  for (genvar i = 0; i < IND_COUNT; i++) begin : g_ind
    localparam ibyte_t RST_VAL = ind_reset_val(i);
    ibyte_t q;
    logic   hit;
    assign hit = wr_en && (wr_idx == IDX_W'(i)) && ind_writable(i);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        q <= RST_VAL;
      else if (soft_clr) q <= RST_VAL;
      else if (hit)      q <= ind_store_val(i, wdata);
    end
    assign regs_o[i] = q;
  end

endmodule

// File: rtl/codec_read_mux.sv
module codec_read_mux
  import codec_regs_pkg::*;
#(
  parameter int DIR_COUNT = 16,
  parameter int IND_COUNT = 32,
  localparam int WORD_AW = $clog2(DIR_COUNT),
  localparam int IDX_W   = $clog2(IND_COUNT)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       rd_en,
  input  logic [WORD_AW-1:0]         rd_word,
  input  logic [IDX_W-1:0]           idx,
  input  logic [DIR_COUNT-1:0][31:0] dir_regs,
  input  logic [IND_COUNT-1:0][7:0]  ind_regs,
  output word_t                      rdata
);

  word_t sel;

  always_comb begin
    if (rd_word == WORD_AW'(WORD_DATA))
      sel = {24'h0, ind_read_val(int'(idx), ind_regs[idx])};
    else
      sel = dir_regs[rd_word];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= sel;
  end

endmodule

// File: rtl/codec_regfile.sv
module codec_regfile
  import codec_regs_pkg::*;
#(
  parameter int DIR_COUNT = 16,
  parameter int IND_COUNT = 32,
  localparam int WORD_AW = $clog2(DIR_COUNT),
  localparam int IDX_W   = $clog2(IND_COUNT),
  localparam int ADDR_W  = WORD_AW + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq
);

  logic [DIR_COUNT-1:0][31:0] dir_regs;
  logic [IND_COUNT-1:0][7:0]  ind_regs;

  logic [WORD_AW-1:0] word_sel;
  logic [IDX_W-1:0]   cur_index;
  logic               data_port_wr;
  logic               soft_clr;
  word_t              ctrl_q;
  ibyte_t             codec_ver_q;
  ibyte_t             chip_ver_q;

  assign word_sel     = bus_addr[ADDR_W-1:2];
  assign cur_index    = dir_regs[WORD_INDEX][IDX_W-1:0];
  assign data_port_wr = bus_wr && (word_sel == WORD_AW'(WORD_DATA));
  assign soft_clr     = bus_wr && (word_sel == WORD_AW'(WORD_CTRL)) && bus_wdata[SOFT_RST_BIT];
  assign ctrl_q       = dir_regs[WORD_CTRL];
  assign codec_ver_q  = ind_regs[IDX_CODECVER];
  assign chip_ver_q   = ind_regs[IDX_CHIPVER];
  assign irq          = 1'b0;

  codec_dir_bank #(.DIR_COUNT(DIR_COUNT)) u_dir (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (bus_wr),
    .wr_word  (word_sel),
    .wdata    (bus_wdata),
    .soft_clr (soft_clr),
    .regs_o   (dir_regs)
  );

  codec_ind_bank #(.IND_COUNT(IND_COUNT)) u_ind (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (data_port_wr),
    .wr_idx   (cur_index),
    .wdata    (bus_wdata[7:0]),
    .soft_clr (soft_clr),
    .regs_o   (ind_regs)
  );

  codec_read_mux #(.DIR_COUNT(DIR_COUNT), .IND_COUNT(IND_COUNT)) u_rd (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_en    (bus_rd),
    .rd_word  (word_sel),
    .idx      (cur_index),
    .dir_regs (dir_regs),
    .ind_regs (ind_regs),
    .rdata    (bus_rdata)
  );

endmodule

// File: rtl/codec_regfile_chk.sv
module codec_regfile_chk #(
  parameter int WORD_AW = 4,
  parameter int IDX_W   = 5
) (
  input logic               clk,
  input logic               rst_n,
  input logic               bus_rd,
  input logic [31:0]        bus_wdata,
  input logic [31:0]        bus_rdata,
  input logic               irq,
  input logic [WORD_AW-1:0] word_sel,
  input logic [IDX_W-1:0]   cur_index,
  input logic               soft_clr,
  input logic [31:0]        ctrl_q,
  input logic [7:0]         codec_ver_q,
  input logic [7:0]         chip_ver_q
);

  assert_wonly_reads_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd && word_sel == WORD_AW'(1) && cur_index == IDX_W'(3) |=> bus_rdata == 32'h0);

  assert_chip_ver_locked_R5: assert property (@(posedge clk) disable iff (!rst_n)
    chip_ver_q == 8'hA0);

  assert_codec_ver_bits_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (codec_ver_q & 8'hBF) == 8'h8A);

  assert_zero_word_reads_R7: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd && word_sel == WORD_AW'(2) |=> bus_rdata == 32'h0);

  assert_ctrl_width_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q[31:7] == 25'h0);

  assert_soft_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    soft_clr |=> cur_index == '0 && ctrl_q == {25'h0, $past(bus_wdata[6:0])} && codec_ver_q == 8'h8A);

  assert_rdata_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata));

  assert_irq_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
    irq == 1'b0);

endmodule

bind codec_regfile codec_regfile_chk #(.WORD_AW(WORD_AW), .IDX_W(IDX_W)) u_chk (.*);

// File: tb/codec_regfile_test.sv
module codec_regfile_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;

  int    n_run = 0;
  int    n_fail = 0;
  bit    finished = 0;
  string phase = "R1";

  logic [31:0] m_dir [16];
  logic [7:0]  m_ind [32];
  logic [31:0] exp_rd = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  codec_regfile uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  function automatic void model_reset();
    foreach (m_dir[k]) m_dir[k] = 32'h0;
    foreach (m_ind[k]) m_ind[k] = 8'h0;
    m_ind[12] = 8'h8A;
    m_ind[25] = 8'hA0;
  endfunction

  function automatic logic [31:0] model_read(int w);
    int k;
    k = int'(m_dir[0] % 32);
    if (w == 1) return (k == 3) ? 32'h0 : {24'h0, m_ind[k]};
    if (w == 2) return 32'h0;
    return m_dir[w];
  endfunction

  function automatic void model_write(int w, logic [31:0] v);
    int k;
    k = int'(m_dir[0] % 32);
    case (w)
      1: begin
        if (k == 12)                 m_ind[k] = 8'h8A | (v[7:0] & 8'h40);
        else if (k != 11 && k != 25) m_ind[k] = v[7:0];
      end
      2: ;
      4: begin
        if (v[0]) model_reset();
        m_dir[4] = v % 128;
      end
      default: m_dir[w] = v;
    endcase
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // reference model compared on every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check({phase, " (model)"}, bus_rdata, exp_rd);
      check("R11 irq", {31'h0, irq}, 32'h0);
    end
  end

  task automatic bus(int w, bit rd, bit wr, logic [31:0] v);
    @(negedge clk);
    bus_addr  = 6'(w * 4);
    bus_rd    = rd;
    bus_wr    = wr;
    bus_wdata = v;
    @(posedge clk);
    #1;
    if (rd) exp_rd = model_read(w);
    if (wr) model_write(w, v);
    bus_rd = 1'b0;
    bus_wr = 1'b0;
  endtask

  task automatic wr(int w, logic [31:0] v);
    bus(w, 0, 1, v);
  endtask

  task automatic rd_expect(int w, logic [31:0] exp, string req);
    bus(w, 1, 0, 32'h0);
    @(negedge clk);
    check(req, bus_rdata, exp);
  endtask

  function automatic logic [7:0] slot_val(int i);
    return 8'(i * 9 + 1);
  endfunction

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1
    phase = "R1";
    for (int w = 0; w < 16; w++) rd_expect(w, 32'h0, "R1 direct");
    wr(0, 12); rd_expect(1, 32'h8A, "R1 ind12");
    wr(0, 25); rd_expect(1, 32'hA0, "R1 ind25");

    // R2
    phase = "R2";
    for (int w = 3; w < 16; w++) begin
      if (w == 4) continue;
      wr(w, 32'hA5A5_0000 ^ (w * 32'h0101_0101));
    end
    wr(0, 32'hDEAD_BEE0);
    for (int w = 3; w < 16; w++) begin
      if (w == 4) continue;
      rd_expect(w, 32'hA5A5_0000 ^ (w * 32'h0101_0101), "R2 plain");
    end
    rd_expect(0, 32'hDEAD_BEE0, "R2 word0");

    // R3, R4, R5, R6
    phase = "R3";
    for (int i = 0; i < 32; i++) begin
      wr(0, 32'h1234_5660 | i);
      wr(1, 32'hFFFF_FF00 | slot_val(i));
    end
    for (int i = 0; i < 32; i++) begin
      logic [7:0] e;
      wr(0, 32'hFFFF_FFE0 | i);
      if (i == 3)       e = 8'h00;
      else if (i == 11) e = 8'h00;
      else if (i == 25) e = 8'hA0;
      else if (i == 12) e = 8'h8A | (slot_val(i) & 8'h40);
      else              e = slot_val(i);
      if (i == 3)       rd_expect(1, {24'h0, e}, "R4 write-only slot");
      else if (i == 11 || i == 25) rd_expect(1, {24'h0, e}, "R5 locked slot");
      else if (i == 12) rd_expect(1, {24'h0, e}, "R6 version slot");
      else              rd_expect(1, {24'h0, e}, "R3 indexed slot");
    end
    phase = "R6";
    wr(0, 12); wr(1, 32'hFF); rd_expect(1, 32'hCA, "R6 all ones");
    wr(1, 32'h00); rd_expect(1, 32'h8A, "R6 all zeros");

    // R7
    phase = "R7";
    wr(2, 32'hFFFF_FFFF); rd_expect(2, 32'h0, "R7 zero word");

    // R8
    phase = "R8";
    wr(4, 32'hFFFF_FFFE);
    rd_expect(4, 32'h7E, "R8 ctrl mask");
    rd_expect(3, 32'hA5A5_0000 ^ 32'h0303_0303, "R8 neighbour kept");
    wr(0, 5); rd_expect(1, {24'h0, slot_val(5)}, "R8 slot kept");

    // R12
    phase = "R12";
    wr(6, 32'h11);
    bus(6, 1, 1, 32'h22);
    @(negedge clk); check("R12 old value", bus_rdata, 32'h11);
    rd_expect(6, 32'h22, "R12 new value");

    // R10
    phase = "R10";
    rd_expect(3, 32'hA5A5_0000 ^ 32'h0303_0303, "R10 setup");
    wr(3, 32'h0);
    repeat (3) @(negedge clk);
    check("R10 hold", bus_rdata, 32'hA5A5_0000 ^ 32'h0303_0303);

    // R9
    phase = "R9";
    wr(3, 32'h5555_AAAA);
    wr(0, 5);
    wr(4, 32'hFFFF_FF81);
    rd_expect(4, 32'h01, "R9 ctrl stored");
    rd_expect(0, 32'h0, "R9 index cleared");
    rd_expect(3, 32'h0, "R9 plain cleared");
    rd_expect(6, 32'h0, "R9 plain cleared");
    rd_expect(1, 32'h0, "R9 slot0 cleared");
    wr(0, 5);  rd_expect(1, 32'h0,  "R9 slot5 cleared");
    wr(0, 12); rd_expect(1, 32'h8A, "R9 codec version");
    wr(0, 25); rd_expect(1, 32'hA0, "R9 chip version");

    // R11
    phase = "R11";
    @(negedge clk); check("R11 irq", {31'h0, irq}, 32'h0);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_run++;
      n_fail++;
      $display("FAIL R10 watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule